// File: doc/BRIEF.md
# Q-Channel Block Capture and Serial Readout

This block gathers the 96-bit Q channel of one subcode block. It receives one bit per frame, and the bits are framed by a block-sync strobe. It runs a CRC over the collected block. Only a block that passes the check is moved into a host-visible register. A host reads that register over a three-wire serial link:

- an active-low chip select,
- a host-driven serial clock,
- a data pin that the block drives only while the host has it selected.

Collection starts at the falling edge of the block-sync strobe, which is high during the two sync frames. The next 96 frame strobes each sample the Q input. The first 80 bits are data and the last 16 bits are an inverted check word. If a block completes while the host is reading, it is parked and delivered once chip select returns high. A status flag tells the host that a block it has not yet read is waiting. Serial clock and chip select are synchronised into the system clock domain, so the serial clock must be much slower than the system clock.

Top module: `subq_crc_reader`

## Requirements
- R1: A block starts at a falling edge of `blk_sync`. While `blk_sync` stays low, each `frame_stb` pulse samples `q_bit`, and the 96th sample completes the block. In the host register, bit 95 holds the first bit received and bit 0 holds the last.
- R2: The first 80 received bits pass through the CRC x^16+x^12+x^5+1. The CRC starts from zero and takes the earliest bit first. The block passes when its last 16 bits, read with the first of them as the MSB, equal the bitwise inverse of the CRC remainder.
- R3: `crc_ok` is 0 after reset. When each block completes, `crc_ok` takes that block's pass/fail result.
- R4: A block that fails the check leaves the host register unchanged.
- R5: While `cs_n` is high, `sdo_oe` is 0 and `sdo` is high-impedance. A few system clocks after `cs_n` falls, `sdo_oe` is 1.
- R6: After `cs_n` falls, register bit 0 is on `sdo` before the first rising edge of `sclk`. Each falling edge of `sclk` moves `sdo` to the next higher bit, so the 96 bits leave LSB first. `sclk` idles low.
- R7: The host register does not change while `cs_n` is low. A block that passes during a read is loaded once `cs_n` is high again, and the next read returns that block.
- R8: `fresh` goes to 1 when a passing block is loaded into the host register. It goes to 0 when a read starts (`cs_n` falls).
- R9: If `blk_sync` rises before the 96th sample, the partial block is dropped. Neither `crc_ok` nor the host register changes.
- R10: Synchronous active-high `rst` clears the host register to zero and brings `crc_ok`, `fresh` and `sdo_oe` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame; samples `q_bit` |
| blk_sync | input | 1 | High during the sync frames of a block |
| q_bit | input | 1 | Q channel bit of the current frame |
| cs_n | input | 1 | Host chip select, active low |
| sclk | input | 1 | Host serial clock, idles low |
| crc_ok | output | 1 | Check result of the last completed block |
| fresh | output | 1 | Unread valid block is in the host register |
| sdo_oe | output | 1 | Serial data output enable |
| sdo | output | 1 | Serial data, high-impedance when deselected |

## Verification
The bench uses the default sizes: 96 bits per block and a 16-bit check word. At those sizes one full read takes about 1500 system clocks, while a whole block arrives in about 400 clocks. That lets a complete passing block land in the middle of a read, which is the case R7 is about. Data patterns cover a corrupted data bit, a corrupted check bit and a block that sync cuts short. Each read-back is compared with a value the bench works out from its own CRC function.

// File: rtl/subq_pkg.sv
package subq_pkg;
  localparam int unsigned Q_BITS_DEF = 96;
  localparam int unsigned CRC_W_DEF  = 16;
  localparam logic [15:0] CRC_POLY_DEF = 16'h1021;

  typedef enum logic {COL_IDLE, COL_RUN} col_state_e;
endpackage

// File: rtl/subq_collect.sv
module subq_collect
  import subq_pkg::*;
#(
  parameter int unsigned QBITS = Q_BITS_DEF,
  parameter int unsigned CRCW  = CRC_W_DEF,
  parameter logic [CRCW-1:0] POLY = CRC_POLY_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             blk_sync,
  input  logic             q_bit,
  output logic             done,
  output logic             pass,
  output logic [QBITS-1:0] data
);
  localparam int unsigned DATAW = QBITS - CRCW;
  localparam int unsigned CNTW  = $clog2(QBITS + 1);

  col_state_e       st;
  logic             bs_q;
  logic [CNTW-1:0]  cnt;
  logic [QBITS-1:0] sh;
  logic [CRCW-1:0]  crc;
  logic             done_q;
  logic             sync_fall;

  assign sync_fall = bs_q & ~blk_sync;

  function automatic logic [CRCW-1:0] crc_step(input logic [CRCW-1:0] c, input logic b);
    logic fb;
    fb = c[CRCW-1] ^ b;
    return {c[CRCW-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= COL_IDLE;
      bs_q   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      crc    <= '0;
      done_q <= 1'b0;
    end else begin
      bs_q   <= blk_sync;
      done_q <= 1'b0;
      if (sync_fall) begin
        st  <= COL_RUN;
        cnt <= '0;
        crc <= '0;
      end else if (blk_sync) begin
        st <= COL_IDLE;
      end else if (st == COL_RUN && frame_stb) begin
        sh  <= {sh[QBITS-2:0], q_bit};
        cnt <= cnt + 1'b1;
        if (cnt < CNTW'(DATAW)) crc <= crc_step(crc, q_bit);
        if (cnt == CNTW'(QBITS - 1)) begin
          done_q <= 1'b1;
          st     <= COL_IDLE;
        end
      end
    end
  end

  assign done = done_q;
  assign pass = (sh[CRCW-1:0] == ~crc);
  assign data = sh;

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CNTW'(QBITS));
  // R1
  done_cnt_chk: assert property (@(posedge clk) disable iff (rst) done_q |-> cnt == CNTW'(QBITS));
  // R2
  crc_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= CNTW'(DATAW) && !sync_fall) |=> $stable(crc));
endmodule

// File: rtl/subq_hold.sv
module subq_hold #(
  parameter int unsigned QBITS = subq_pkg::Q_BITS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             pass,
  input  logic [QBITS-1:0] data,
  input  logic             reading,
  input  logic             rd_start,
  output logic             crc_ok,
  output logic             fresh,
  output logic [QBITS-1:0] out_data
);
  logic [QBITS-1:0] pend_q;
  logic             pend_v;
  logic [QBITS-1:0] out_q;
  logic             crc_ok_q;
  logic             fresh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      pend_v   <= 1'b0;
      out_q    <= '0;
      crc_ok_q <= 1'b0;
      fresh_q  <= 1'b0;
    end else begin
      if (done) begin
        crc_ok_q <= pass;
        if (pass) begin
          pend_q <= data;
          pend_v <= 1'b1;
        end
      end
      if (pend_v && !reading) begin
        out_q   <= pend_q;
        fresh_q <= 1'b1;
        if (!(done && pass)) pend_v <= 1'b0;
      end
      if (rd_start) fresh_q <= 1'b0;
    end
  end

  assign crc_ok   = crc_ok_q;
  assign fresh    = fresh_q;
  assign out_data = out_q;

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst) reading |=> $stable(out_q));
  // R8
  fresh_clr_chk: assert property (@(posedge clk) disable iff (rst) rd_start |=> !fresh_q);
  // R4
  fail_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !pass && !pend_v) |=> !pend_v);
  // R3
  result_chk: assert property (@(posedge clk) disable iff (rst) done |=> crc_ok_q == $past(pass));
endmodule

// File: rtl/subq_serout.sv
module subq_serout #(
  parameter int unsigned QBITS = subq_pkg::Q_BITS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [QBITS-1:0] out_data,
  output logic             reading,
  output logic             rd_start,
  output logic             oe,
  output logic             bit_out
);
  logic cs1, cs2, cs3;
  logic k1, k2, k3;
  logic adv;
  logic oe_q;
  logic [QBITS-1:0] sh;

  assign reading  = ~cs2;
  assign rd_start = cs3 & ~cs2;
  assign adv      = k3 & ~k2 & ~cs2 & ~rd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs1  <= 1'b1;
      cs2  <= 1'b1;
      cs3  <= 1'b1;
      k1   <= 1'b0;
      k2   <= 1'b0;
      k3   <= 1'b0;
      oe_q <= 1'b0;
      sh   <= '0;
    end else begin
      cs1  <= cs_n;
      cs2  <= cs1;
      cs3  <= cs2;
      k1   <= sclk;
      k2   <= k1;
      k3   <= k2;
      oe_q <= ~cs2;
      if (rd_start) sh <= out_data;
      else if (adv) sh <= {1'b0, sh[QBITS-1:1]};
    end
  end

  assign oe      = oe_q;
  assign bit_out = sh[0];

  // R5
  oe_off_chk: assert property (@(posedge clk) disable iff (rst) cs3 |-> !oe_q);
  // R6
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_start && !adv) |=> $stable(sh));
endmodule

// File: rtl/subq_crc_reader.sv
module subq_crc_reader
  import subq_pkg::*;
#(
  parameter int unsigned QBITS = Q_BITS_DEF,
  parameter int unsigned CRCW  = CRC_W_DEF,
  parameter logic [CRCW-1:0] POLY = CRC_POLY_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic blk_sync,
  input  logic q_bit,
  input  logic cs_n,
  input  logic sclk,
  output logic crc_ok,
  output logic fresh,
  output logic sdo_oe,
  output wire  sdo
);
  logic             done;
  logic             pass;
  logic [QBITS-1:0] blk_data;
  logic [QBITS-1:0] host_data;
  logic             reading;
  logic             rd_start;
  logic             bit_out;

  subq_collect #(.QBITS(QBITS), .CRCW(CRCW), .POLY(POLY)) u_collect (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .blk_sync(blk_sync), .q_bit(q_bit),
    .done(done), .pass(pass), .data(blk_data)
  );

  subq_hold #(.QBITS(QBITS)) u_hold (
    .clk(clk), .rst(rst), .done(done), .pass(pass), .data(blk_data),
    .reading(reading), .rd_start(rd_start),
    .crc_ok(crc_ok), .fresh(fresh), .out_data(host_data)
  );

  subq_serout #(.QBITS(QBITS)) u_serout (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .out_data(host_data),
    .reading(reading), .rd_start(rd_start), .oe(sdo_oe), .bit_out(bit_out)
  );

  assign sdo = sdo_oe ? bit_out : 1'bz;
endmodule

// File: tb/subq_crc_reader_bench.sv
module subq_crc_reader_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic blk_sync = 1'b0;
  logic q_bit = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic crc_ok, fresh, sdo_oe;
  wire  sdo;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  subq_crc_reader u_subq_crc_reader (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .blk_sync(blk_sync), .q_bit(q_bit),
    .cs_n(cs_n), .sclk(sclk), .crc_ok(crc_ok), .fresh(fresh), .sdo_oe(sdo_oe), .sdo(sdo)
  );

  function automatic logic [15:0] ref_crc(input logic [79:0] d);
    logic [15:0] c;
    logic fb;
    c = '0;
    for (int i = 79; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [95:0] good_blk(input logic [79:0] d);
    return {d, ~ref_crc(d)};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic frame(input logic b);
    @(negedge clk);
    q_bit = b;
    frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_block(input logic [95:0] blk, input int nbits);
    blk_sync = 1'b1;
    frame(1'b0);
    frame(1'b0);
    blk_sync = 1'b0;
    for (int i = 0; i < nbits; i++) frame(blk[95-i]);
    if (nbits < 96) begin
      blk_sync = 1'b1;
      frame(1'b0);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic read_reg(output logic [95:0] got);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    chk(sdo_oe === 1'b1, "R5 oe during read", {95'd0, sdo_oe}, 96'd1);
    for (int i = 0; i < 96; i++) begin
      got[i] = sdo;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [95:0] got, blk_a, blk_b, blk_c, blk_d, corrupt;
    blk_a = good_blk(80'h0123_4567_89AB_CDEF_1357);
    blk_b = good_blk(80'hFFFF_FFFF_FFFF_FFFF_FFFF);
    blk_c = good_blk(80'hA5A5_5A5A_0F0F_F0F0_8001);
    blk_d = good_blk(80'h0000_0000_0000_0000_0001);

    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk(crc_ok === 1'b0, "R10 crc_ok reset", {95'd0, crc_ok}, 96'd0);
    chk(fresh === 1'b0, "R10 fresh reset", {95'd0, fresh}, 96'd0);
    chk(sdo_oe === 1'b0, "R5 oe idle", {95'd0, sdo_oe}, 96'd0);
    read_reg(got);
    chk(got === 96'd0, "R10 register reset", got, 96'd0);

    // R1 R2 R3 R8 good block
    send_block(blk_a, 96);
    chk(crc_ok === 1'b1, "R3 pass on good block", {95'd0, crc_ok}, 96'd1);
    chk(fresh === 1'b1, "R8 fresh after load", {95'd0, fresh}, 96'd1);
    read_reg(got);
    chk(got === blk_a, "R1 R6 read back order", got, blk_a);
    chk(fresh === 1'b0, "R8 fresh cleared by read", {95'd0, fresh}, 96'd0);
    chk(sdo_oe === 1'b0, "R5 oe after read", {95'd0, sdo_oe}, 96'd0);

    // R2 R4 corrupted data bit
    corrupt = blk_b ^ (96'd1 << 50);
    send_block(corrupt, 96);
    chk(crc_ok === 1'b0, "R2 fail on data error", {95'd0, crc_ok}, 96'd0);
    chk(fresh === 1'b0, "R4 no fresh on fail", {95'd0, fresh}, 96'd0);
    read_reg(got);
    chk(got === blk_a, "R4 register kept", got, blk_a);

    // R2 corrupted check bit
    corrupt = blk_b ^ 96'd4;
    send_block(corrupt, 96);
    chk(crc_ok === 1'b0, "R2 fail on check error", {95'd0, crc_ok}, 96'd0);

    // R2 good all-ones block
    send_block(blk_b, 96);
    chk(crc_ok === 1'b1, "R2 pass all ones", {95'd0, crc_ok}, 96'd1);

    // R9 aborted partial block
    send_block(blk_d ^ 96'd1, 40);
    chk(crc_ok === 1'b1, "R9 crc_ok unchanged", {95'd0, crc_ok}, 96'd1);
    read_reg(got);
    chk(got === blk_b, "R9 register unchanged", got, blk_b);

    // R7 block arrives during read
    fork
      read_reg(got);
      begin
        repeat (50) @(negedge clk);
        send_block(blk_c, 96);
        chk(crc_ok === 1'b1, "R7 block passes mid read", {95'd0, crc_ok}, 96'd1);
        chk(fresh === 1'b0, "R7 not loaded mid read", {95'd0, fresh}, 96'd0);
      end
    join
    chk(got === blk_b, "R7 read unaffected", got, blk_b);
    chk(fresh === 1'b1, "R7 R8 loaded after deselect", {95'd0, fresh}, 96'd1);
    read_reg(got);
    chk(got === blk_c, "R7 newer block read", got, blk_c);

    // R6 sparse pattern
    send_block(blk_d, 96);
    read_reg(got);
    chk(got === blk_d, "R6 sparse pattern", got, blk_d);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule